// File: doc/BRIEF.md
# Mode-Routed Internal Data Memory

This block is the internal scratch memory of an 8-bit controller. It holds 256 bytes of general-purpose RAM. It also decodes a second space, the special-function registers, which shares the upper half of the byte address range with that RAM. The addressing mode of each byte access decides which space is reached. An indirect access always lands in RAM. A direct access to the upper half is passed out on a strobe-style special-function-register bus, and the data that bus returns is handed back to the requester.

Besides the byte port, the block has two more ports. A working-register port accepts a register index 0–7 and relocates it into one of four eight-byte banks, chosen by a two-bit bank select taken from the status word. A single-bit port reaches the 128 addressable bits held in a sixteen-byte window of the lower RAM. A bit write is done as a read-modify-write inside one cycle. All three ports can be active in the same cycle. Every read result is registered.

Top module: `idm_core`

## Requirements
- R1: Byte addresses 0x00–0x7F reach the same RAM byte whether `b_indirect` is 0 (direct) or 1 (indirect).
- R2: With `b_indirect`=1, addresses 0x80–0xFF read and write the upper 128 RAM bytes, and `sfr_sel` stays 0.
- R3: With `b_indirect`=0 and `b_addr`[7]=1, in the same cycle the block drives `sfr_sel`=1, `sfr_we`=`b_we`, `sfr_addr`=`b_addr` and `sfr_wdata`=`b_wdata`. The RAM byte at that address is not changed. One cycle later, `b_rdata` shows the `sfr_rdata` value that was present in the request cycle.
- R4: A working-register access to index n with `bank_sel`=b reaches RAM byte b×8+n. Bank 0 covers 0x00–0x07 and bank 3 covers 0x18–0x1F.
- R5: Bit address a (7 bits) reaches RAM byte 0x20+(a>>3), at bit position a[2:0]. A bit write changes only that bit, and a bit read returns it on `bit_rval`.
- R6: Each read port presents its data one cycle after the request. When a port has no request, its output holds. A read from the same address as a write in the same cycle returns the old content. A byte write also loads the old content onto `b_rdata`.
- R7: When writes from several ports hit the same byte in one cycle, the byte port wins over the working-register port, which wins over the bit port. Writes to different bytes in the same cycle all take effect.
- R8: After reset, `b_rdata`, `wr_rdata` and `bit_rval` are 0, and `sfr_sel` is 0 while no byte request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| b_req | input | 1 | Byte access request |
| b_we | input | 1 | Byte access is a write |
| b_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| b_addr | input | 8 | Byte address |
| b_wdata | input | 8 | Byte write data |
| b_rdata | output | 8 | Byte read data (registered) |
| bit_req | input | 1 | Bit access request |
| bit_we | input | 1 | Bit access is a write |
| bit_addr | input | 7 | Bit address |
| bit_wval | input | 1 | Bit write value |
| bit_rval | output | 1 | Bit read value (registered) |
| bank_sel | input | 2 | Active register bank |
| wr_req | input | 1 | Working-register request |
| wr_we | input | 1 | Working-register access is a write |
| wr_idx | input | 3 | Register index 0–7 |
| wr_wdata | input | 8 | Working-register write data |
| wr_rdata | output | 8 | Working-register read data (registered) |
| sfr_sel | output | 1 | Special-function-register access strobe |
| sfr_we | output | 1 | Special-function-register write |
| sfr_addr | output | 8 | Special-function-register address |
| sfr_wdata | output | 8 | Special-function-register write data |
| sfr_rdata | input | 8 | Special-function-register read data |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, four banks of eight registers, and the bit window starting at 0x20. With these values, a sweep that writes all 256 RAM bytes and reads them back by both addressing modes takes only a few hundred cycles. The same defaults keep every bank boundary, the last bit of the bit window and the upper-half split close enough to test directly. Same-cycle collisions between ports are driven on purpose to expose the write priority and the old-data read rule.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int BANK_W     = 2;
  localparam int IDX_W      = 3;
  localparam int BITA_W     = 7;
  localparam int POS_W      = 3;
  localparam int BIT_BASE   = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BITA_W-1:0] bita_t;
  typedef logic [POS_W-1:0]  pos_t;

  // bank times eight plus index
  function automatic addr_t wreg_phys(bank_t b, idx_t i);
    addr_t r;
    r = '0;
    r[IDX_W +: BANK_W] = b;
    r[IDX_W-1:0] = i;
    return r;
  endfunction

  function automatic addr_t bit_byte(bita_t a);
    addr_t off;
    off = '0;
    off[BITA_W-POS_W-1:0] = a[BITA_W-1:POS_W];
    return addr_t'(BIT_BASE) + off;
  endfunction

  function automatic pos_t bit_pos(bita_t a);
    return a[POS_W-1:0];
  endfunction

  function automatic data_t bit_merge(data_t d, pos_t p, logic v);
    data_t r;
    r = d;
    r[p] = v;
    return r;
  endfunction
endpackage

// File: rtl/idm_route.sv
module idm_route
  import idm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  b_req,
  input  logic  b_we,
  input  logic  b_indirect,
  input  addr_t b_addr,
  input  data_t b_wdata,
  output logic  ram_rd,
  output logic  ram_we,
  output logic  sfr_hit,
  output logic  sfr_sel,
  output logic  sfr_we,
  output addr_t sfr_addr,
  output data_t sfr_wdata
);
  logic upper_half;

  assign upper_half = b_addr[ADDR_W-1];
  assign sfr_hit    = b_req && !b_indirect && upper_half;
  assign ram_rd     = b_req && !sfr_hit;
  assign ram_we     = b_req && b_we && !sfr_hit;
  assign sfr_sel    = sfr_hit;
  assign sfr_we     = sfr_hit && b_we;
  assign sfr_addr   = b_addr;
  assign sfr_wdata  = b_wdata;

  // R2: indirect accesses never leave the RAM
  a_r2_indirect_stays_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && b_indirect) |-> (!sfr_sel && ram_rd));

  // R3: a special-function-register access never writes the RAM
  a_r3_sfr_blocks_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> !ram_we);
endmodule

// File: rtl/idm_bitmap.sv
module idm_bitmap
  import idm_pkg::*;
(
  input  bita_t bit_addr,
  output addr_t byte_addr,
  output pos_t  pos
);
  assign byte_addr = bit_byte(bit_addr);
  assign pos       = bit_pos(bit_addr);
endmodule

// File: rtl/idm_store.sv
module idm_store
  import idm_pkg::*;
#(
  parameter int DEPTH = 1 << ADDR_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_rd,
  input  logic  a_we,
  input  addr_t a_addr,
  input  data_t a_wdata,
  output data_t a_rdata,
  input  logic  r_rd,
  input  logic  r_we,
  input  addr_t r_addr,
  input  data_t r_wdata,
  output data_t r_rdata,
  input  logic  t_rd,
  input  logic  t_we,
  input  addr_t t_addr,
  input  pos_t  t_pos,
  input  logic  t_wval,
  output logic  t_rval
);
  data_t mem [DEPTH];
  data_t t_merged;

  assign t_merged = bit_merge(mem[t_addr], t_pos, t_wval);

  // later assignments win: bit < register < byte
  always_ff @(posedge clk) begin
    if (t_we) mem[t_addr] <= t_merged;
    if (r_we) mem[r_addr] <= r_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      r_rdata <= '0;
      t_rval  <= 1'b0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (r_rd) r_rdata <= mem[r_addr];
      if (t_rd) t_rval  <= mem[t_addr][t_pos];
    end
  end

  // R6: read data is the content before any same-cycle write
  a_r6_byte_read_old: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd |=> (a_rdata == $past(mem[a_addr])));

  // R7: byte port beats register port on a shared byte
  a_r7_byte_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && r_we && a_addr == r_addr) |=> (mem[$past(a_addr)] == $past(a_wdata)));

  // R5: bit write changes only its own bit
  a_r5_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (t_we && !(a_we && a_addr == t_addr) && !(r_we && r_addr == t_addr)) |=>
      ((((mem[$past(t_addr)] ^ $past(mem[t_addr])) & ~(data_t'(1) << $past(t_pos))) == '0)
       && (mem[$past(t_addr)][$past(t_pos)] == $past(t_wval))));
endmodule

// File: rtl/idm_core.sv
module idm_core
  import idm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                b_req,
  input  logic                b_we,
  input  logic                b_indirect,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic [DATA_W-1:0]   b_rdata,
  input  logic                bit_req,
  input  logic                bit_we,
  input  logic [BITA_W-1:0]   bit_addr,
  input  logic                bit_wval,
  output logic                bit_rval,
  input  logic [BANK_W-1:0]   bank_sel,
  input  logic                wr_req,
  input  logic                wr_we,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_wdata,
  output logic [DATA_W-1:0]   wr_rdata,
  output logic                sfr_sel,
  output logic                sfr_we,
  output logic [ADDR_W-1:0]   sfr_addr,
  output logic [DATA_W-1:0]   sfr_wdata,
  input  logic [DATA_W-1:0]   sfr_rdata
);
  logic  byte_ram_rd, byte_ram_we, sfr_hit;
  addr_t wreg_addr, bit_byte_addr;
  pos_t  bit_position;
  data_t ram_byte_q, sfr_q;
  logic  from_sfr_q;

  idm_route u_route (
    .clk(clk), .rst_n(rst_n),
    .b_req(b_req), .b_we(b_we), .b_indirect(b_indirect),
    .b_addr(b_addr), .b_wdata(b_wdata),
    .ram_rd(byte_ram_rd), .ram_we(byte_ram_we), .sfr_hit(sfr_hit),
    .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata)
  );

  assign wreg_addr = wreg_phys(bank_sel, wr_idx);

  idm_bitmap u_bitmap (
    .bit_addr(bit_addr), .byte_addr(bit_byte_addr), .pos(bit_position)
  );

  idm_store u_store (
    .clk(clk), .rst_n(rst_n),
    .a_rd(byte_ram_rd), .a_we(byte_ram_we), .a_addr(b_addr),
    .a_wdata(b_wdata), .a_rdata(ram_byte_q),
    .r_rd(wr_req), .r_we(wr_req && wr_we), .r_addr(wreg_addr),
    .r_wdata(wr_wdata), .r_rdata(wr_rdata),
    .t_rd(bit_req), .t_we(bit_req && bit_we), .t_addr(bit_byte_addr),
    .t_pos(bit_position), .t_wval(bit_wval), .t_rval(bit_rval)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      from_sfr_q <= 1'b0;
      sfr_q      <= '0;
    end else if (b_req) begin
      from_sfr_q <= sfr_hit;
      if (sfr_hit) sfr_q <= sfr_rdata;
    end
  end

  assign b_rdata = from_sfr_q ? sfr_q : ram_byte_q;

  // R3: bus data returns one cycle after the strobe
  a_r3_sfr_return: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |=> (b_rdata == $past(sfr_rdata)));

  // R4: register accesses stay within the bank area
  a_r4_bank_area: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wreg_addr < addr_t'(BIT_BASE)));

  // R8: outputs are cleared in reset
  always_comb begin
    if (!rst_n) begin
      a_r8_reset_clear: assert (b_rdata == '0 && wr_rdata == '0 && !bit_rval);
    end
  end
endmodule

// File: tb/idm_core_bench.sv
module idm_core_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic b_req = 0, b_we = 0, b_indirect = 0;
  logic [7:0] b_addr = 0, b_wdata = 0, b_rdata;
  logic bit_req = 0, bit_we = 0, bit_wval = 0, bit_rval;
  logic [6:0] bit_addr = 0;
  logic [1:0] bank_sel = 0;
  logic wr_req = 0, wr_we = 0;
  logic [2:0] wr_idx = 0;
  logic [7:0] wr_wdata = 0, wr_rdata;
  logic sfr_sel, sfr_we;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata = 0;

  int checks = 0, failures = 0;
  logic [7:0] model [256];
  bit done = 0;

  always #10 clk = ~clk;

  idm_core u_idm_core (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    b_req = 0; b_we = 0; wr_req = 0; wr_we = 0; bit_req = 0; bit_we = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic byte_acc(bit we, bit ind, logic [7:0] a, logic [7:0] d);
    b_req = 1; b_we = we; b_indirect = ind; b_addr = a; b_wdata = d;
    step();
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) ^ 8'h5A);
  endfunction

  task automatic t_reset();
    chk("R8 b_rdata", b_rdata, 0);
    chk("R8 wr_rdata", wr_rdata, 0);
    chk("R8 bit_rval", bit_rval, 0);
    chk("R8 sfr_sel", sfr_sel, 0);
  endtask

  task automatic t_fill_sweep();
    int bad1 = 0, bad2 = 0;
    for (int a = 0; a < 128; a++) begin byte_acc(1, 0, 8'(a), pat(a)); model[a] = pat(a); end
    for (int a = 128; a < 256; a++) begin byte_acc(1, 1, 8'(a), pat(a)); model[a] = pat(a); end
    for (int a = 0; a < 128; a++) begin
      byte_acc(0, 1, 8'(a), 0); if (b_rdata != model[a]) bad1++;
      byte_acc(0, 0, 8'(a), 0); if (b_rdata != model[a]) bad1++;
    end
    chk("R1 lower half same by both modes (mismatches)", bad1, 0);
    for (int a = 128; a < 256; a++) begin
      byte_acc(0, 1, 8'(a), 0); if (b_rdata != model[a]) bad2++;
    end
    chk("R2 upper RAM via indirect (mismatches)", bad2, 0);
    byte_acc(0, 1, 8'h7F, 0); chk("R1 0x7F indirect", b_rdata, model[127]);
    b_req = 1; b_we = 0; b_indirect = 1; b_addr = 8'h80; #1;
    chk("R2 no strobe on indirect upper", sfr_sel, 0);
    step(); chk("R2 0x80 indirect", b_rdata, model[128]);
  endtask

  task automatic t_sfr();
    b_req = 1; b_we = 1; b_indirect = 0; b_addr = 8'h90; b_wdata = 8'hFF; #1;
    chk("R3 sfr_sel", sfr_sel, 1);
    chk("R3 sfr_we", sfr_we, 1);
    chk("R3 sfr_addr", sfr_addr, 8'h90);
    chk("R3 sfr_wdata", sfr_wdata, 8'hFF);
    step();
    byte_acc(0, 1, 8'h90, 0); chk("R3 RAM untouched by direct upper write", b_rdata, model[8'h90]);
    sfr_rdata = 8'h5A;
    b_req = 1; b_we = 0; b_indirect = 0; b_addr = 8'hC3; #1;
    chk("R3 sfr_we on read", sfr_we, 0);
    step(); sfr_rdata = 8'h00;
    chk("R3 returned bus data", b_rdata, 8'h5A);
    step(); chk("R6 output holds without request", b_rdata, 8'h5A);
  endtask

  task automatic t_wreg();
    int bad = 0;
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      for (int n = 0; n < 8; n++) begin
        wr_req = 1; wr_we = 1; wr_idx = 3'(n); wr_wdata = 8'(b * 16 + n + 1);
        step(); model[b * 8 + n] = 8'(b * 16 + n + 1);
      end
    end
    for (int a = 0; a < 32; a++) begin byte_acc(0, 0, 8'(a), 0); if (b_rdata != model[a]) bad++; end
    chk("R4 bank layout via byte port (mismatches)", bad, 0);
    bank_sel = 2'b11; wr_req = 1; wr_idx = 3'd7; step();
    chk("R4 bank3 R7 at 0x1F", wr_rdata, model[31]);
    bank_sel = 2'b00; wr_req = 1; wr_idx = 3'd0; step();
    chk("R4 bank0 R0 at 0x00", wr_rdata, model[0]);
  endtask

  task automatic t_bits();
    byte_acc(1, 0, 8'h21, 8'hA5); model[8'h21] = 8'hA5;
    bit_req = 1; bit_we = 1; bit_addr = 7'h0B; bit_wval = 1; step();
    byte_acc(0, 0, 8'h21, 0); chk("R5 set bit3 of 0x21", b_rdata, 8'hAD);
    bit_req = 1; bit_we = 1; bit_addr = 7'h08; bit_wval = 0; step();
    byte_acc(0, 0, 8'h21, 0); chk("R5 clear bit0 of 0x21", b_rdata, 8'hAC);
    bit_req = 1; bit_addr = 7'h0D; step(); chk("R5 read bit5", bit_rval, 1);
    bit_req = 1; bit_addr = 7'h0C; step(); chk("R5 read bit4", bit_rval, 0);
    byte_acc(1, 0, 8'h2F, 8'h00);
    bit_req = 1; bit_we = 1; bit_addr = 7'h7F; bit_wval = 1; step();
    byte_acc(0, 1, 8'h2F, 0); chk("R5 last bit maps to 0x2F bit7", b_rdata, 8'h80);
  endtask

  task automatic t_collide();
    byte_acc(1, 0, 8'h05, 8'h33);
    bank_sel = 0; b_req = 1; b_we = 1; b_indirect = 0; b_addr = 8'h05; b_wdata = 8'h77;
    wr_req = 1; wr_we = 0; wr_idx = 3'd5; step();
    chk("R6 byte write returns old", b_rdata, 8'h33);
    chk("R6 register read during write old", wr_rdata, 8'h33);
    wr_req = 1; wr_idx = 3'd5; step(); chk("R6 new value after write", wr_rdata, 8'h77);
    b_req = 1; b_we = 1; b_indirect = 1; b_addr = 8'h03; b_wdata = 8'h11;
    wr_req = 1; wr_we = 1; wr_idx = 3'd3; wr_wdata = 8'h22; step();
    byte_acc(0, 0, 8'h03, 0); chk("R7 byte beats register", b_rdata, 8'h11);
    b_req = 1; b_we = 1; b_indirect = 0; b_addr = 8'h24; b_wdata = 8'hF0;
    bit_req = 1; bit_we = 1; bit_addr = 7'h20; bit_wval = 1; step();
    byte_acc(0, 0, 8'h24, 0); chk("R7 byte beats bit", b_rdata, 8'hF0);
    b_req = 1; b_we = 1; b_indirect = 1; b_addr = 8'hE0; b_wdata = 8'h44;
    wr_req = 1; wr_we = 1; wr_idx = 3'd6; wr_wdata = 8'h55; step();
    byte_acc(0, 1, 8'hE0, 0); chk("R7 distinct byte write lands", b_rdata, 8'h44);
    wr_req = 1; wr_idx = 3'd6; step(); chk("R7 distinct register write lands", wr_rdata, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fill_sweep();
    t_sfr();
    t_wreg();
    t_bits();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule